// File: doc/BRIEF.md
# Dual-Law SPI Serial Clock Divider

This block derives the serial clock of an SPI host from the bus clock. Software programs a divider value and a control word through a small write port. A law bit in the control word selects one of two division laws. The power-of-two law divides by 2^(N+1), using only the low four bits of the divider. The linear law divides by 2*(N+1), using the full 8-bit divider. The same control word sets the resting level of the clock (polarity) and the sampling edge (phase). It also holds the global enable.

Shift logic raises `frame_run` for the length of a frame. While it is high and the block is enabled, the divider counts bus cycles and toggles `sclk` on each terminal count. Each toggle comes with a one-cycle `half_stb`. A `sample_stb` marks the toggles on which the receiver should capture data. When the frame ends, `sclk` returns to its idle level, and the count starts again from zero at the next frame.

Configuration is locked while the block is enabled. Divider writes are then dropped, and a control write can change only the enable bit. This keeps the clock shape stable for the length of a transfer.

Top module: `spi_sclk_div`

## Requirements
- R1: After reset, enable, polarity, phase and law are all 0 and the divider is 0. `sclk`, `half_stb` and `sample_stb` are low.
- R2: With the law bit clear, the `sclk` period is 2^(N+1) bus cycles, where N is divider bits [3:0]. Divider bits [7:4] have no effect in this law.
- R3: With the law bit set, the `sclk` period is 2*(N+1) bus cycles, for N from 0 to 255 over the whole divider.
- R4: If `frame_run` is low or enable is clear at a clock edge, `sclk` equals the polarity bit after that edge and no strobe is issued.
- R5: `half_stb` is high for exactly the cycles in which `sclk` has just changed level. Pulses are spaced by half a period. The first pulse comes half a period after `frame_run` is first sampled high, so every frame restarts the count from zero.
- R6: With phase 0, `sample_stb` accompanies the edges that leave the idle level. With phase 1, it accompanies the edges that return to it. It is never high without `half_stb`.
- R7: While enable is set, divider writes are ignored. Control writes then change only the enable bit.
- R8: While enable is clear, a write to either register takes effect at the next clock edge. Control word encoding on `cfg_wdata`: bit 0 enable, bit 1 polarity, bit 2 phase, bit 3 law. `cfg_sel` = 0 selects the control word and 1 selects the divider.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 = control word, 1 = divider |
| cfg_wdata | input | 8 | Write data |
| frame_run | input | 1 | High while shift logic transfers a frame |
| sclk | output | 1 | Serial clock |
| half_stb | output | 1 | One-cycle pulse on every `sclk` change |
| sample_stb | output | 1 | One-cycle pulse on data capture edges |

## Verification
A wrong terminal count or law decode moves the first `half_stb` away from its expected cycle, so it is visible on the first half period of a frame. A counter that is not cleared between frames shifts the first toggle after `frame_run` rises again. A configuration register that accepts a write while enabled shows up in the next frame as a different period or idle level. A wrong edge classification places `sample_stb` on the wrong parity of toggles within the first full period.

// File: rtl/sclkdiv_pkg.sv
package sclkdiv_pkg;

  typedef enum logic {
    LAW_POW2   = 1'b0,
    LAW_LINEAR = 1'b1
  } law_e;

  // Packed from MSB: law [3], phase [2], polarity [1], enable [0]
  typedef struct packed {
    law_e law;
    logic pha;
    logic pol;
    logic en;
  } ctrl_t;

  localparam int CTRL_W = 4;

endpackage

// File: rtl/sclkdiv_cfg.sv
module sclkdiv_cfg
  import sclkdiv_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             sel,
  input  logic [DIV_W-1:0] wdata,
  output ctrl_t            ctrl,
  output logic [DIV_W-1:0] div
);

  ctrl_t            ctrl_q, ctrl_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             ctrl_ld, div_ld;

  always_comb begin
    ctrl_ld = we && !sel;
    div_ld  = we && sel && !ctrl_q.en;
    ctrl_d  = ctrl_q;
    div_d   = div_q;
    if (ctrl_ld) begin
      if (ctrl_q.en) ctrl_d.en = wdata[0];
      else           ctrl_d    = ctrl_t'(wdata[CTRL_W-1:0]);
    end
    if (div_ld) div_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      div_q  <= '0;
    end else begin
      if (ctrl_ld) ctrl_q <= ctrl_d;
      if (div_ld)  div_q  <= div_d;
    end
  end

  assign ctrl = ctrl_q;
  assign div  = div_q;

endmodule

// File: rtl/sclkdiv_term.sv
module sclkdiv_term
  import sclkdiv_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int EXP_W = 4,
  parameter int CNT_W = 15
) (
  input  law_e             law,
  input  logic [DIV_W-1:0] div,
  output logic [CNT_W-1:0] term
);

  logic [CNT_W-1:0] pow2_term;
  logic [CNT_W-1:0] lin_term;

  // 2^N - 1: low N bits set
  assign pow2_term = ~({CNT_W{1'b1}} << div[EXP_W-1:0]);

  generate
    if (CNT_W > DIV_W) begin : g_ext
      assign lin_term = {{(CNT_W-DIV_W){1'b0}}, div};
    end else begin : g_same
      assign lin_term = div[CNT_W-1:0];
    end
  endgenerate

  assign term = (law == LAW_LINEAR) ? lin_term : pow2_term;

endmodule

// File: rtl/sclkdiv_gen.sv
module sclkdiv_gen #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             pol,
  input  logic             pha,
  input  logic             run,
  input  logic [CNT_W-1:0] term,
  output logic             sclk,
  output logic             half_stb,
  output logic             sample_stb
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sclk_q, sclk_d;
  logic             hstb_q, hstb_d;
  logic             sstb_q, sstb_d;
  logic             active, at_term;

  always_comb begin
    active  = en && run;
    at_term = (cnt_q == term);
    cnt_d   = cnt_q;
    sclk_d  = sclk_q;
    hstb_d  = 1'b0;
    sstb_d  = 1'b0;
    if (!active) begin
      cnt_d  = '0;
      sclk_d = pol;
    end else if (at_term) begin
      cnt_d  = '0;
      sclk_d = ~sclk_q;
      hstb_d = 1'b1;
      sstb_d = (sclk_q == pol) ^ pha;
    end else begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
      hstb_q <= 1'b0;
      sstb_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
      hstb_q <= hstb_d;
      sstb_q <= sstb_d;
    end
  end

  assign sclk       = sclk_q;
  assign half_stb   = hstb_q;
  assign sample_stb = sstb_q;

endmodule

// File: rtl/spi_sclk_div.sv
module spi_sclk_div
  import sclkdiv_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [DIV_W-1:0] cfg_wdata,
  input  logic             frame_run,
  output logic             sclk,
  output logic             half_stb,
  output logic             sample_stb
);

  localparam int POW_W = (1 << EXP_W) - 1;
  localparam int CNT_W = (POW_W > DIV_W) ? POW_W : DIV_W;

  logic             rst_s0, rst_q;
  ctrl_t            ctrl;
  logic [DIV_W-1:0] div;
  logic [CNT_W-1:0] term;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0 <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_s0 <= 1'b1;
      rst_q  <= rst_s0;
    end
  end

  sclkdiv_cfg #(.DIV_W(DIV_W)) u_cfg (
    .clk   (clk),
    .rst_n (rst_q),
    .we    (cfg_we),
    .sel   (cfg_sel),
    .wdata (cfg_wdata),
    .ctrl  (ctrl),
    .div   (div)
  );

  sclkdiv_term #(.DIV_W(DIV_W), .EXP_W(EXP_W), .CNT_W(CNT_W)) u_term (
    .law  (ctrl.law),
    .div  (div),
    .term (term)
  );

  sclkdiv_gen #(.CNT_W(CNT_W)) u_gen (
    .clk        (clk),
    .rst_n      (rst_q),
    .en         (ctrl.en),
    .pol        (ctrl.pol),
    .pha        (ctrl.pha),
    .run        (frame_run),
    .term       (term),
    .sclk       (sclk),
    .half_stb   (half_stb),
    .sample_stb (sample_stb)
  );

endmodule

// File: rtl/sclkdiv_chk.sv
module sclkdiv_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_run,
  input logic             en,
  input logic             pol,
  input logic [DIV_W-1:0] div,
  input logic             sclk,
  input logic             half_stb,
  input logic             sample_stb
);

  AST_STB_MEANS_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    half_stb |-> (sclk != $past(sclk))); // R5

  AST_TOGGLE_HAS_STB: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(frame_run && en) && (sclk != $past(sclk))) |-> half_stb); // R5

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!frame_run || !en) |-> (sclk == $past(pol) && !half_stb)); // R4

  AST_SAMPLE_IN_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> half_stb); // R6

  AST_DIV_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en) |-> $stable(div)); // R7

endmodule

bind spi_sclk_div sclkdiv_chk #(.DIV_W(DIV_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_q),
  .frame_run  (frame_run),
  .en         (ctrl.en),
  .pol        (ctrl.pol),
  .div        (div),
  .sclk       (sclk),
  .half_stb   (half_stb),
  .sample_stb (sample_stb)
);

// File: tb/test_spi_sclk_div.sv
module test_spi_sclk_div;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic       cfg_sel;
  logic [7:0] cfg_wdata;
  logic       frame_run;
  logic       sclk;
  logic       half_stb;
  logic       sample_stb;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  spi_sclk_div i_spi_sclk_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .frame_run  (frame_run),
    .sclk       (sclk),
    .half_stb   (half_stb),
    .sample_stb (sample_stb)
  );

  // {law, divider, expected half period}
  localparam logic [24:0] VEC [9] = '{
    {1'b0, 8'd0,   16'd1},
    {1'b0, 8'd1,   16'd2},
    {1'b0, 8'd3,   16'd8},
    {1'b0, 8'h13,  16'd8},
    {1'b0, 8'd10,  16'd1024},
    {1'b1, 8'd0,   16'd1},
    {1'b1, 8'd1,   16'd2},
    {1'b1, 8'd4,   16'd5},
    {1'b1, 8'd255, 16'd256}
  };

  task automatic check(bit ok, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic wr(bit sel, logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(bit law, bit pol, bit pha, logic [7:0] dv);
    wr(1'b0, {4'b0, law, pha, pol, 1'b0});
    wr(1'b1, dv);
    wr(1'b0, {4'b0, law, pha, pol, 1'b1});
  endtask

  task automatic measure(int half, bit pol, bit pha, string tag);
    int bad_edge = 0;
    int bad_smp  = 0;
    bit s_half   = 1'b0;
    bit s_full   = 1'b0;
    @(negedge clk);
    frame_run = 1'b1;
    for (int i = 1; i <= 3 * half; i++) begin
      int k;
      bit e_stb, e_smp, e_sclk;
      @(negedge clk);
      k      = i / half;
      e_stb  = (i % half) == 0;
      e_smp  = e_stb && ((k % 2 == 1) ^ pha);
      e_sclk = pol ^ (k % 2 == 1);
      if (half_stb !== e_stb || sclk !== e_sclk) bad_edge++;
      if (sample_stb !== e_smp) bad_smp++;
      if (i == half)     s_half = sclk;
      if (i == 2 * half) s_full = sclk;
    end
    check(bad_edge == 0, {tag, " R5 edge timing mismatches"}, bad_edge, 0);
    check(s_half == !pol, {tag, " R5 level after half period"}, s_half, !pol);
    check(s_full == pol, {tag, " full period level"}, s_full, pol);
    check(bad_smp == 0, {tag, " R6 sample strobe mismatches"}, bad_smp, 0);
    frame_run = 1'b0;
    @(negedge clk);
    check(sclk == pol && !half_stb, {tag, " R4 idle after frame"}, sclk, pol);
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0; frame_run = 1'b0;
    repeat (3) @(negedge clk);
    check(sclk == 1'b0 && !half_stb && !sample_stb, "R1 outputs in reset", sclk, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(sclk == 1'b0 && !half_stb, "R1 outputs after reset", sclk, 0);

    // R1/R4: enable clear after reset, so frame_run does nothing
    begin
      int pulses = 0;
      frame_run = 1'b1;
      repeat (12) begin
        @(negedge clk);
        if (half_stb || sclk) pulses++;
      end
      frame_run = 1'b0;
      check(pulses == 0, "R1 R4 no clock while disabled", pulses, 0);
    end

    // Table walk: R2 (law 0) and R3 (law 1)
    for (int v = 0; v < 9; v++) begin
      bit law, pol, pha;
      int half;
      law  = VEC[v][24];
      half = int'(VEC[v][15:0]);
      pol  = v[0];
      pha  = v[1];
      setup(law, pol, pha, VEC[v][23:16]);
      measure(half, pol, pha, law ? "R3" : "R2");
    end

    // R7: writes while enabled
    setup(1'b1, 1'b0, 1'b0, 8'd1);
    wr(1'b1, 8'd9);
    wr(1'b0, 8'h07);
    measure(2, 1'b0, 1'b0, "R7 locked config");
    wr(1'b0, 8'h0E);
    begin
      int pulses = 0;
      frame_run = 1'b1;
      repeat (10) begin
        @(negedge clk);
        if (half_stb || sclk) pulses++;
      end
      frame_run = 1'b0;
      check(pulses == 0, "R7 enable bit still writable", pulses, 0);
    end

    // R8: disabled writes take effect next edge
    wr(1'b0, 8'h0A);
    @(negedge clk);
    check(sclk == 1'b1, "R8 new polarity idle level", sclk, 1);
    wr(1'b1, 8'd4);
    wr(1'b0, 8'h0B);
    measure(5, 1'b1, 1'b0, "R8 new divider");

    // R5: count restarts when a frame ends early
    setup(1'b1, 1'b0, 1'b0, 8'd3);
    @(negedge clk);
    frame_run = 1'b1;
    repeat (6) @(negedge clk);
    frame_run = 1'b0;
    @(negedge clk);
    check(sclk == 1'b0, "R4 R5 aborted frame idle", sclk, 0);
    measure(4, 1'b0, 1'b0, "R5 restart");

    // R6 with polarity 1 and phase 1 on linear law
    setup(1'b1, 1'b1, 1'b1, 8'd2);
    measure(3, 1'b1, 1'b1, "R6 pol1 pha1");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule